// File: doc/BRIEF.md
# SMBus host transaction controller

This block sits between a byte-wide register port and a byte-level bus engine. Software loads the target address, the command byte and the data bytes into small registers. It then writes a control byte whose start bit launches one transaction. The sequencer breaks the transaction into engine operations: start condition, write byte, read byte with acknowledge, read byte with no acknowledge, and stop condition. It issues them one at a time and waits for the engine's completion pulse after each.

Six transfer kinds are supported: quick, byte, byte-data, word-data, SMBus block and I2C block. Every read that carries a command uses a repeated start. Block transfers move one byte at a time through the block data register. After each byte the sequencer raises byte-done and pauses until software clears that flag. Progress and errors are reported in a status register whose flags are cleared by writing ones. A kill bit in the control byte aborts a running transfer.

Top module: `smbus_host_ctl`

## Requirements
- R1: After reset the status, control and auxiliary control registers read 0x00. Offsets 3 (command), 4 (address), 5 (data0), 6 (data1), 7 (block data) and 8 (PEC) are plain 8-bit registers that read back what was written. Offset 13 keeps only bits 1:0 (bit 0 PEC enable, bit 1 buffer mode) and reads other bits as zero.
- R2: Starting a transfer:
  - A write to offset 2 with bit 6 set, while idle, starts a transfer when bits 4:2 hold 0 (quick), 1 (byte), 2 (byte-data), 3 (word-data), 5 (block) or 6 (I2C block).
  - Status bit 0 (busy) is set from the next cycle.
  - Bit 6 always reads back as zero.
- R3: Engine operations are coded as eng_op 0 start, 1 stop, 2 write byte, 3 read with ack and 4 read with nack. Writes issue the following sequences, then stop:
  - Quick: start, then the address register unchanged.
  - Byte: start, address, command.
  - Byte-data: start, address with bit 0 cleared, command, data0.
  - Word-data: as byte-data, then data1.
- R4: A read is selected by address bit 0.
  - Byte read sends start and the address, then reads one byte with nack into data0.
  - Byte-data and word-data reads send start, the address with bit 0 cleared and the command. They then send a repeated start and the address with bit 0 set.
  - Word reads fill data0 (low byte, ack) and then data1 (high byte, nack). Byte-data reads fill data0 with nack.
- R5: Block write:
  - An SMBus block write sends the data0 count byte after the command. An I2C block write does not.
  - It then sends data0 bytes taken from offset 7.
  - Status bit 7 (byte-done) is set after each byte. No further engine request is made until software clears it.
- R6: Block reads:
  - An SMBus block read first stores the slave's count byte in data0.
  - An I2C block read sends data1 as the command, with the first address phase having bit 0 cleared.
  - Each received byte goes to offset 7 and sets byte-done.
  - A byte is read with nack, and then stopped, when control bit 5 (the 0x34/0x38 last-byte forms) is set at the time it is issued.
- R7: A transfer that ends with a clean stop clears busy and sets status bit 1 (done). No other event sets the done flag.
- R8: A write byte answered with nack sets status bit 2 (device error). The transfer then goes straight to stop, and done stays clear.
- R9: Arbitration loss on any operation sets status bit 3 (bus error) and ends the transfer with a stop, without done.
- R10: Control bit 1 (kill) set while busy clears busy one cycle later and sets status bit 4 (failed). The engine request drops and no further operations follow.
- R11: A start written while busy is ignored. The running transfer keeps its kind and sequence.
- R12: A start with an unsupported selection in bits 4:2 sets failed and causes no bus activity.
- R13: Writing a one to a status flag bit (7, 6, 5, 4, 3, 2 or 1) clears it. Writing zero leaves it unchanged.
- R14: Status bit 6 (in-use) is set by a read strobe on offset 0. Status bit 5 (alert) is set while the alert input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on offset 0 only) |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| alert_in | input | 1 | Alert request from the bus |
| eng_req | output | 1 | Engine operation requested |
| eng_op | output | 3 | Operation code (see R3) |
| eng_wbyte | output | 8 | Byte to send for a write operation |
| eng_done | input | 1 | One-cycle completion pulse for the current operation |
| eng_nack | input | 1 | Written byte was not acknowledged (valid with eng_done) |
| eng_arb_lost | input | 1 | Arbitration lost (valid with eng_done) |
| eng_rbyte | input | 8 | Received byte (valid with eng_done) |

## Verification
Timing of results relative to the stimulus:

- Register writes take effect at the capturing edge, so read-back and the busy flag are sampled at the following falling edge.
- Kill acts one edge after the control write lands. The bench waits one more rising edge before it samples busy, failed and eng_req.
- Each engine operation ends with a completion pulse from the bench's engine model, which answers after a fixed latency. Results of a transfer (the operation log, data registers and done or error flags) are therefore checked only after a bounded poll sees busy fall. Byte-done pauses are checked by waiting a further ten cycles and confirming that the operation count has not moved.

// File: rtl/smbus_host_ctl.sv
module smbus_host_ctl #(
  parameter int AW = 4,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          alert_in,
  output logic          eng_req,
  output logic [2:0]    eng_op,
  output logic [7:0]    eng_wbyte,
  input  logic          eng_done,
  input  logic          eng_nack,
  input  logic          eng_arb_lost,
  input  logic [7:0]    eng_rbyte
);
  localparam logic [AW-1:0] A_STS = AW'(0), A_CTL = AW'(2), A_CMD = AW'(3), A_ADR = AW'(4),
                            A_D0 = AW'(5), A_D1 = AW'(6), A_BLK = AW'(7), A_PEC = AW'(8),
                            A_AUXS = AW'(12), A_AUXC = AW'(13);
  localparam logic [2:0] P_QUICK = 3'd0, P_BYTE = 3'd1, P_BDATA = 3'd2, P_WORD = 3'd3,
                         P_BLOCK = 3'd5, P_I2C = 3'd6;
  localparam logic [2:0] OP_START = 3'd0, OP_STOP = 3'd1, OP_WR = 3'd2, OP_RACK = 3'd3, OP_RNACK = 3'd4;

  typedef enum logic [3:0] {S_IDLE, S_START, S_ADDR, S_CMD, S_CNT, S_WR,
                            S_RSTART, S_RADDR, S_RD, S_WAITBD, S_STOP} st_t;

  st_t st;
  logic [7:0] ctl, cmd, adr, d0, d1, blk, pec;
  logic [1:0] aux;
  logic f_bd, f_inuse, f_alert, f_fail, f_bus, f_dev, f_intr;
  logic [2:0] xp;
  logic xrd, idx, cnt_ph, err;
  logic [CW-1:0] left;

  wire busy     = (st != S_IDLE);
  wire wr_ctl   = reg_wr && (reg_addr == A_CTL);
  wire wr_sts   = reg_wr && (reg_addr == A_STS);
  wire sel_ok   = (reg_wdata[4:2] inside {P_QUICK, P_BYTE, P_BDATA, P_WORD, P_BLOCK, P_I2C});
  wire start_ok = wr_ctl && reg_wdata[6] && !busy && sel_ok;
  wire start_bad = wr_ctl && reg_wdata[6] && !busy && !sel_ok;
  wire kill     = busy && ctl[1];
  wire is_blk   = (xp == P_BLOCK) || (xp == P_I2C);

  assign eng_req = busy && (st != S_WAITBD) && !ctl[1];
  wire done_ok   = eng_req && eng_done;
  wire wr_nack   = done_ok && (eng_op == OP_WR) && eng_nack && !eng_arb_lost;
  wire rd_done   = done_ok && (st == S_RD) && !eng_arb_lost;

  always_comb begin
    case (st)
      S_START, S_RSTART: eng_op = OP_START;
      S_STOP:            eng_op = OP_STOP;
      S_RD: eng_op = ((xp == P_BYTE) || (xp == P_BDATA) || ((xp == P_WORD) && idx) ||
                      (is_blk && !cnt_ph && ctl[5])) ? OP_RNACK : OP_RACK;
      default:           eng_op = OP_WR;
    endcase
    case (st)
      S_ADDR:  eng_wbyte = ((xp == P_QUICK) || (xp == P_BYTE)) ? adr : {adr[7:1], 1'b0};
      S_CMD:   eng_wbyte = ((xp == P_I2C) && xrd) ? d1 : cmd;
      S_CNT:   eng_wbyte = d0;
      S_WR:    eng_wbyte = is_blk ? blk : (((xp == P_WORD) && idx) ? d1 : d0);
      S_RADDR: eng_wbyte = {adr[7:1], 1'b1};
      default: eng_wbyte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; xp <= P_QUICK; xrd <= 1'b0; idx <= 1'b0; cnt_ph <= 1'b0; err <= 1'b0; left <= '0;
    end else if (kill) begin
      st <= S_IDLE;
    end else if (start_ok) begin
      st <= S_START; xp <= reg_wdata[4:2]; xrd <= adr[0]; idx <= 1'b0; err <= 1'b0;
      cnt_ph <= (reg_wdata[4:2] == P_BLOCK) && adr[0];
      left <= d0[CW-1:0];
    end else if (done_ok) begin
      if (st == S_STOP) st <= S_IDLE;
      else if (eng_arb_lost || ((eng_op == OP_WR) && eng_nack)) begin
        st <= S_STOP; err <= 1'b1;
      end else begin
        case (st)
          S_START:  st <= S_ADDR;
          S_RSTART: st <= S_RADDR;
          S_RADDR:  st <= S_RD;
          S_ADDR: begin
            if (xp == P_QUICK) st <= S_STOP;
            else if ((xp == P_BYTE) && xrd) st <= S_RD;
            else st <= S_CMD;
          end
          S_CMD: begin
            if (xp == P_BYTE) st <= S_STOP;
            else if (xrd) st <= S_RSTART;
            else if (xp == P_BLOCK) st <= S_CNT;
            else if ((xp == P_I2C) && (left == '0)) st <= S_STOP;
            else st <= S_WR;
          end
          S_CNT: st <= (left == '0) ? S_STOP : S_WR;
          S_WR: begin
            if (is_blk) begin
              left <= left - 1'b1;
              st <= (left == CW'(1)) ? S_STOP : S_WAITBD;
            end else if ((xp == P_WORD) && !idx) idx <= 1'b1;
            else st <= S_STOP;
          end
          S_RD: begin
            if (is_blk) begin
              if (cnt_ph) cnt_ph <= 1'b0;
              else st <= (eng_op == OP_RNACK) ? S_STOP : S_WAITBD;
            end else if ((xp == P_WORD) && !idx) idx <= 1'b1;
            else st <= S_STOP;
          end
          default: st <= st;
        endcase
      end
    end else if ((st == S_WAITBD) && !f_bd) begin
      st <= xrd ? S_RD : S_WR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0; cmd <= '0; adr <= '0; d0 <= '0; d1 <= '0; blk <= '0; pec <= '0; aux <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CTL:  ctl <= reg_wdata & 8'hBF;
          A_CMD:  cmd <= reg_wdata;
          A_ADR:  adr <= reg_wdata;
          A_D0:   d0  <= reg_wdata;
          A_D1:   d1  <= reg_wdata;
          A_BLK:  blk <= reg_wdata;
          A_PEC:  pec <= reg_wdata;
          A_AUXC: aux <= reg_wdata[1:0];
          default: ;
        endcase
      end
      if (rd_done) begin
        if (is_blk) begin
          if (cnt_ph) d0 <= eng_rbyte;
          else blk <= eng_rbyte;
        end else if ((xp == P_WORD) && idx) d1 <= eng_rbyte;
        else d0 <= eng_rbyte;
      end
    end
  end

  wire [7:0] clr = wr_sts ? reg_wdata : 8'h00;
  wire set_bd = done_ok && !eng_arb_lost && is_blk &&
                (((st == S_WR) && !eng_nack) || ((st == S_RD) && !cnt_ph));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_bd <= 1'b0; f_inuse <= 1'b0; f_alert <= 1'b0; f_fail <= 1'b0;
      f_bus <= 1'b0; f_dev <= 1'b0; f_intr <= 1'b0;
    end else begin
      f_bd    <= (f_bd    & ~clr[7]) | set_bd;
      f_inuse <= (f_inuse & ~clr[6]) | (reg_rd && (reg_addr == A_STS));
      f_alert <= (f_alert & ~clr[5]) | alert_in;
      f_fail  <= (f_fail  & ~clr[4]) | kill | start_bad;
      f_bus   <= (f_bus   & ~clr[3]) | (done_ok && eng_arb_lost);
      f_dev   <= (f_dev   & ~clr[2]) | wr_nack;
      f_intr  <= (f_intr  & ~clr[1]) | (done_ok && (st == S_STOP) && !err && !eng_arb_lost);
    end
  end

  always_comb begin
    case (reg_addr)
      A_STS:   reg_rdata = {f_bd, f_inuse, f_alert, f_fail, f_bus, f_dev, f_intr, busy};
      A_CTL:   reg_rdata = ctl;
      A_CMD:   reg_rdata = cmd;
      A_ADR:   reg_rdata = adr;
      A_D0:    reg_rdata = d0;
      A_D1:    reg_rdata = d1;
      A_BLK:   reg_rdata = blk;
      A_PEC:   reg_rdata = pec;
      A_AUXS:  reg_rdata = 8'h00;
      A_AUXC:  reg_rdata = {6'b0, aux};
      default: reg_rdata = 8'h00;
    endcase
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (busy && eng_op == OP_START)); // R2
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_intr) |-> $past(eng_op == OP_STOP && eng_done)); // R7
  AST_NACK_DEVERR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_nack |=> (f_dev && st == S_STOP)); // R8
  AST_ARB_BUSERR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok && eng_arb_lost) |=> f_bus); // R9
  AST_KILL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!busy && f_fail && !eng_req)); // R10
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && reg_wdata[6] && busy && !ctl[1] && !eng_done && st != S_WAITBD) |=> $stable(st)); // R11
endmodule

// File: tb/tb_smbus_host_ctl.sv
module tb_smbus_host_ctl;
  localparam int CLK_P = 10;
  localparam int LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic alert_in = 1'b0;
  logic eng_req, eng_done, eng_nack, eng_arb_lost;
  logic [2:0] eng_op;
  logic [7:0] eng_wbyte, eng_rbyte;

  int n_chk = 0, n_fail = 0;
  int nops, cnt, nack_at = -1, arb_at = -1;
  logic clr_log = 1'b0;
  logic [2:0] op_log [0:31];
  logic [7:0] wb_log [0:31];

  always #(CLK_P/2) clk = ~clk;

  smbus_host_ctl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alert_in(alert_in),
    .eng_req(eng_req), .eng_op(eng_op), .eng_wbyte(eng_wbyte), .eng_done(eng_done),
    .eng_nack(eng_nack), .eng_arb_lost(eng_arb_lost), .eng_rbyte(eng_rbyte));

  always @(posedge clk) begin
    if (!rst_n || clr_log) begin
      eng_done <= 1'b0; eng_nack <= 1'b0; eng_arb_lost <= 1'b0; eng_rbyte <= 8'h00;
      cnt <= 0; nops <= 0;
    end else if (eng_done) begin
      if (eng_req && nops < 32) begin
        op_log[nops] <= eng_op; wb_log[nops] <= eng_wbyte;
      end
      if (eng_req) nops <= nops + 1;
      eng_done <= 1'b0; eng_nack <= 1'b0; eng_arb_lost <= 1'b0;
    end else if (eng_req) begin
      if (cnt == LAT) begin
        eng_done <= 1'b1; cnt <= 0;
        eng_rbyte <= 8'hC0 | 8'(nops);
        eng_nack <= (nops == nack_at);
        eng_arb_lost <= (nops == arb_at);
      end else cnt <= cnt + 1;
    end else cnt <= 0;
  end

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic strobe, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_rd = strobe; #1; v = reg_rdata;
    @(posedge clk); #1; reg_rd = 1'b0;
  endtask

  task automatic clear_log();
    @(negedge clk); clr_log = 1'b1; @(posedge clk); #1; clr_log = 1'b0;
  endtask

  task automatic wait_bit(input int b, input logic val);
    logic [7:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(4'd0, 1'b0, v);
      if (v[b] == val) return;
    end
    chk("poll timeout", 0, 1);
  endtask

  task automatic exp_op(input string req, input int i, input int op, input int wb);
    chk(req, op_log[i], op);
    if (op == 2) chk(req, wb_log[i], wb);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(4'd0, 1'b0, v); chk("R1 status reset", v, 8'h00);
    rd(4'd2, 1'b0, v); chk("R1 control reset", v, 8'h00);
    rd(4'd13, 1'b0, v); chk("R1 aux reset", v, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(4'd3, 8'h5C); wr(4'd4, 8'hA0); wr(4'd5, 8'h12); wr(4'd6, 8'h34);
    wr(4'd7, 8'h9E); wr(4'd8, 8'h6B); wr(4'd13, 8'hFF);
    rd(4'd3, 1'b0, v); chk("R1 cmd", v, 8'h5C);
    rd(4'd4, 1'b0, v); chk("R1 addr", v, 8'hA0);
    rd(4'd5, 1'b0, v); chk("R1 data0", v, 8'h12);
    rd(4'd6, 1'b0, v); chk("R1 data1", v, 8'h34);
    rd(4'd7, 1'b0, v); chk("R1 block", v, 8'h9E);
    rd(4'd8, 1'b0, v); chk("R1 pec", v, 8'h6B);
    rd(4'd13, 1'b0, v); chk("R1 aux mask", v, 8'h03);
    wr(4'd13, 8'h00);
  endtask

  task automatic t_quick();
    logic [7:0] v;
    clear_log(); wr(4'd4, 8'hA0); wr(4'd2, 8'h40);
    rd(4'd0, 1'b0, v); chk("R2 busy after start", v[0], 1);
    rd(4'd2, 1'b0, v); chk("R2 start bit reads 0", v, 8'h00);
    wait_bit(0, 1'b0);
    chk("R3 quick op count", nops, 3);
    exp_op("R3 quick", 0, 0, 0); exp_op("R3 quick", 1, 2, 8'hA0); exp_op("R3 quick", 2, 1, 0);
    rd(4'd0, 1'b0, v); chk("R7 done after quick", v, 8'h02);
    wr(4'd0, 8'h02);
  endtask

  task automatic t_bdata_write();
    logic [7:0] v;
    clear_log(); wr(4'd4, 8'hA0); wr(4'd3, 8'h5C); wr(4'd5, 8'h12); wr(4'd2, 8'h48);
    wait_bit(0, 1'b0);
    chk("R3 byte-data op count", nops, 5);
    exp_op("R3 bdata", 1, 2, 8'hA0); exp_op("R3 bdata", 2, 2, 8'h5C);
    exp_op("R3 bdata", 3, 2, 8'h12); exp_op("R3 bdata", 4, 1, 0);
    rd(4'd0, 1'b0, v); chk("R7 done bdata", v, 8'h02);
    wr(4'd0, 8'h02);
  endtask

  task automatic t_word_read();
    logic [7:0] v;
    clear_log(); wr(4'd4, 8'hA1); wr(4'd3, 8'h21); wr(4'd2, 8'h4C);
    wait_bit(0, 1'b0);
    chk("R4 word read op count", nops, 8);
    exp_op("R4 word", 1, 2, 8'hA0); exp_op("R4 word", 2, 2, 8'h21);
    exp_op("R4 word", 3, 0, 0); exp_op("R4 word", 4, 2, 8'hA1);
    exp_op("R4 word", 5, 3, 0); exp_op("R4 word", 6, 4, 0); exp_op("R4 word", 7, 1, 0);
    rd(4'd5, 1'b0, v); chk("R4 word low in data0", v, 8'hC5);
    rd(4'd6, 1'b0, v); chk("R4 word high in data1", v, 8'hC6);
    wr(4'd0, 8'h02);
  endtask

  task automatic t_byte_read();
    logic [7:0] v;
    clear_log(); wr(4'd4, 8'hA1); wr(4'd2, 8'h44);
    wait_bit(0, 1'b0);
    chk("R4 byte read op count", nops, 4);
    exp_op("R4 byte", 1, 2, 8'hA1); exp_op("R4 byte", 2, 4, 0);
    rd(4'd5, 1'b0, v); chk("R4 byte read data0", v, 8'hC2);
    wr(4'd0, 8'h02);
  endtask

  task automatic t_errors();
    logic [7:0] v;
    clear_log(); nack_at = 1; wr(4'd4, 8'hA0); wr(4'd2, 8'h48);
    wait_bit(0, 1'b0); nack_at = -1;
    chk("R8 nack op count", nops, 3); exp_op("R8 stop after nack", 2, 1, 0);
    rd(4'd0, 1'b0, v); chk("R8 device error no done", v, 8'h04);
    clear_log(); arb_at = 2; wr(4'd2, 8'h48);
    wait_bit(0, 1'b0); arb_at = -1;
    chk("R9 arb op count", nops, 4); exp_op("R9 stop after arb", 3, 1, 0);
    rd(4'd0, 1'b0, v); chk("R9 bus error kept with device error", v, 8'h0C);
    wr(4'd0, 8'h00); rd(4'd0, 1'b0, v); chk("R13 zero write no effect", v, 8'h0C);
    wr(4'd0, 8'h08); rd(4'd0, 1'b0, v); chk("R13 clear bus error only", v, 8'h04);
    wr(4'd0, 8'h04); rd(4'd0, 1'b0, v); chk("R13 clear device error", v, 8'h00);
  endtask

  task automatic t_block_write();
    logic [7:0] v;
    clear_log(); wr(4'd4, 8'hA0); wr(4'd3, 8'h33); wr(4'd5, 8'h02); wr(4'd7, 8'h11);
    wr(4'd2, 8'h54);
    wait_bit(7, 1'b1);
    repeat (10) @(posedge clk);
    chk("R5 paused on byte-done", nops, 5);
    exp_op("R5 count byte", 3, 2, 8'h02); exp_op("R5 first byte", 4, 2, 8'h11);
    rd(4'd0, 1'b0, v); chk("R5 busy during pause", v, 8'h81);
    wr(4'd7, 8'h22); wr(4'd0, 8'h80);
    wait_bit(0, 1'b0);
    chk("R5 block write op count", nops, 7);
    exp_op("R5 second byte", 5, 2, 8'h22); exp_op("R5 stop", 6, 1, 0);
    rd(4'd0, 1'b0, v); chk("R5 byte-done and done at end", v, 8'h82);
    wr(4'd0, 8'h82);
  endtask

  task automatic t_i2c_read();
    logic [7:0] v;
    clear_log(); wr(4'd4, 8'hA1); wr(4'd6, 8'h77); wr(4'd3, 8'h99); wr(4'd2, 8'h58);
    wait_bit(7, 1'b1);
    chk("R6 i2c read ops before pause", nops, 6);
    exp_op("R6 addr bit0 clear", 1, 2, 8'hA0); exp_op("R6 command from data1", 2, 2, 8'h77);
    exp_op("R6 repeated addr", 4, 2, 8'hA1); exp_op("R6 first byte acked", 5, 3, 0);
    rd(4'd7, 1'b0, v); chk("R6 first byte in block", v, 8'hC5);
    wr(4'd2, 8'h38); rd(4'd2, 1'b0, v); chk("R6 last form readback", v, 8'h38);
    wr(4'd0, 8'h80);
    wait_bit(0, 1'b0);
    chk("R6 i2c read op count", nops, 8);
    exp_op("R6 last byte nacked", 6, 4, 0); exp_op("R6 stop", 7, 1, 0);
    rd(4'd7, 1'b0, v); chk("R6 last byte in block", v, 8'hC6);
    rd(4'd0, 1'b0, v); chk("R7 done after i2c read", v, 8'h82);
    wr(4'd0, 8'h82); wr(4'd2, 8'h00);
  endtask

  task automatic t_kill();
    logic [7:0] v;
    int n;
    clear_log(); wr(4'd4, 8'hA1); wr(4'd3, 8'h44); wr(4'd2, 8'h54);
    wait_bit(7, 1'b1);
    rd(4'd5, 1'b0, v); chk("R6 block count in data0", v, 8'hC5);
    rd(4'd7, 1'b0, v); chk("R6 block data byte", v, 8'hC6);
    wr(4'd2, 8'h16);
    @(posedge clk);
    rd(4'd0, 1'b0, v); chk("R10 kill clears busy sets failed", v, 8'h90);
    chk("R10 no engine request", eng_req, 0);
    n = nops;
    repeat (10) @(posedge clk);
    chk("R10 no ops after kill", nops, n);
    wr(4'd2, 8'h00); wr(4'd0, 8'h90);
    rd(4'd0, 1'b0, v); chk("R13 cleared after kill", v, 8'h00);
  endtask

  task automatic t_busy_start();
    logic [7:0] v;
    clear_log(); wr(4'd4, 8'hA0); wr(4'd2, 8'h40); wr(4'd2, 8'h48);
    wait_bit(0, 1'b0);
    chk("R11 quick sequence kept", nops, 3);
    exp_op("R11 stop third", 2, 1, 0);
    rd(4'd0, 1'b0, v); chk("R11 single done", v, 8'h02);
    wr(4'd0, 8'h02);
  endtask

  task automatic t_bad_sel();
    logic [7:0] v;
    clear_log(); wr(4'd2, 8'h50);
    repeat (10) @(posedge clk);
    chk("R12 no bus activity", nops, 0);
    rd(4'd0, 1'b0, v); chk("R12 failed, not busy", v, 8'h10);
    wr(4'd0, 8'h10);
  endtask

  task automatic t_inuse_alert();
    logic [7:0] v;
    rd(4'd0, 1'b1, v); chk("R14 in-use clear before read", v, 8'h00);
    rd(4'd0, 1'b0, v); chk("R14 in-use set by read", v, 8'h40);
    wr(4'd0, 8'h40); rd(4'd0, 1'b0, v); chk("R13 in-use cleared", v, 8'h00);
    @(negedge clk); alert_in = 1'b1; @(negedge clk); alert_in = 1'b0;
    rd(4'd0, 1'b0, v); chk("R14 alert latched", v, 8'h20);
    wr(4'd0, 8'h20); rd(4'd0, 1'b0, v); chk("R13 alert cleared", v, 8'h00);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk); #1; rst_n = 1'b1;
    t_reset(); t_regs(); t_quick(); t_bdata_write(); t_word_read(); t_byte_read();
    t_errors(); t_block_write(); t_i2c_read(); t_kill(); t_busy_start(); t_bad_sel();
    t_inuse_alert();
    finish_run();
  end
endmodule